// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial characters from a receive line. The line is oversampled with a strobe at sixteen times the bit rate, which the surrounding logic supplies. Static line-control inputs select the frame format: 5 to 8 data bits, no parity or odd, even or fixed-level parity, and a receiver that only ever samples one stop bit. A falling edge on the line is accepted as a start bit once a mid-bit sample confirms it. After that, each data bit, the parity bit and the first stop bit are sampled at the centre of the bit.

Every finished character goes into a receive queue together with its parity-error, framing-error and break flags. The consumer sees the head entry and removes it with a one-cycle pop strobe. With the queue enabled it holds up to `DEPTH` entries. With the queue disabled it acts as one hold register. If a character arrives while the store is full, it is dropped and a one-cycle overrun strobe is raised. A break is a frame whose data, parity and stop samples are all low. It produces a single flagged entry, and the receiver then waits for the line to return high.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset the queue is empty: `rxValid` and `overrunPulse` are low.
- R2: A low pulse that has already returned high at the start-bit centre (8 oversample ticks after the edge) produces no character.
- R3: The data-bit count follows `wordLen`: 00=5, 01=6, 10=7, 11=8. Bits arrive LSB first and are delivered right-aligned in `rxData`, with the unused upper bits zero.
- R4: With `parityOn`=1 and `stickSel`=0, the expected parity bit makes the count of ones in data plus parity even when `evenSel`=1 and odd when `evenSel`=0. A mismatch sets `rxParityErr`.
- R5: With `parityOn`=1 and `stickSel`=1, the expected parity bit is fixed: 1 when `evenSel`=0 and 0 when `evenSel`=1. A mismatch sets `rxParityErr`.
- R6: With `parityOn`=0 no parity bit is sampled, and `rxParityErr` stays 0.
- R7: A low first stop bit on a character that is not a break sets `rxFrameErr`, and the data is still delivered.
- R8: All data bits low, a low parity bit (when enabled) and a low stop bit produce one entry with `rxBreak`=1, data 0 and the other flags 0. No further character is taken until the line has been high.
- R9: Only the first stop bit is sampled. Frames sent with one stop bit back to back, and frames sent with two stop bits, are both received correctly.
- R10: With `fifoEn`=1 the queue returns up to `DEPTH` entries in arrival order. A character arriving when it is full is discarded and `overrunPulse` goes high for one cycle.
- R11: With `fifoEn`=0 the store holds one entry. A second character arriving before a pop is discarded with `overrunPulse`. `fifoEn` is changed only while the store is empty.
- R12: A `popReq` while `rxValid` is high removes the head entry. The last entry popped leaves `rxValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| wordLen | input | 2 | Data-bit count select (00=5 to 11=8) |
| parityOn | input | 1 | Parity bit present and checked |
| evenSel | input | 1 | Even (1) or odd (0) parity; selects level in fixed mode |
| stickSel | input | 1 | Fixed-level parity mode |
| fifoEn | input | 1 | 1: multi-entry queue, 0: single hold register |
| popReq | input | 1 | Remove head entry |
| rxValid | output | 1 | Queue holds at least one entry |
| rxData | output | 8 | Head entry data, right-aligned |
| rxParityErr | output | 1 | Head entry parity mismatch |
| rxFrameErr | output | 1 | Head entry stop bit sampled low |
| rxBreak | output | 1 | Head entry is a break |
| overrunPulse | output | 1 | A character was dropped because the store was full |

## Verification
Every cycle, the assertions check that the fill level never exceeds the depth in effect, and that an overrun only happens while entries are waiting. They also check that a break entry always carries zero data and no other flag, that the break-wait state only exits to idle, and that popping the last entry empties the queue. Only the bench's frame scenarios can show the rest. That covers the sampling position and bit order for each word length, the parity rule in every mode, glitch rejection, framing errors, tolerance of one or two stop bits, and the order in which entries come back out of the queue.

// File: rtl/ufr_pkg.sv
package ufr_pkg;
  localparam int MAX_BITS = 8;
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_BRKWAIT
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrShift;
    logic shiftIn;
    logic takeParity;
    logic pushChar;
    logic pushBrk;
  } rxStrobe_t;

  typedef struct packed {
    logic                brk;
    logic                perr;
    logic                ferr;
    logic [MAX_BITS-1:0] data;
  } rxEntry_t;
endpackage

// File: rtl/ufr_ctrl.sv
module ufr_ctrl
  import ufr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic       allLow,
  input  logic       parityOn,
  input  logic [1:0] wordLen,
  output rxStrobe_t  strb,
  output rxState_e   stateQ
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(MAX_BITS);

  rxState_e stateD;
  logic [CW-1:0] cntQ, cntD;
  logic [BW-1:0] bitQ, bitD;
  logic midStart, fullBit;
  logic [BW-1:0] lastIdx;

  assign midStart = (cntQ == CW'(OVS/2 - 1));
  assign fullBit  = (cntQ == CW'(OVS - 1));
  assign lastIdx  = BW'(4) + BW'(wordLen);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    bitD   = bitQ;
    strb   = '0;
    if (tick) begin
      unique case (stateQ)
        ST_IDLE: if (!rxS) begin
          stateD = ST_START;
          cntD   = '0;
        end
        ST_START: begin
          if (midStart) begin
            cntD = '0;
            if (rxS) stateD = ST_IDLE;
            else begin
              stateD = ST_DATA;
              bitD   = '0;
              strb.clrShift = 1'b1;
            end
          end else cntD = cntQ + 1'b1;
        end
        ST_DATA: begin
          if (fullBit) begin
            cntD = '0;
            strb.shiftIn = 1'b1;
            if (bitQ == lastIdx) stateD = parityOn ? ST_PARITY : ST_STOP;
            else bitD = bitQ + 1'b1;
          end else cntD = cntQ + 1'b1;
        end
        ST_PARITY: begin
          if (fullBit) begin
            cntD = '0;
            strb.takeParity = 1'b1;
            stateD = ST_STOP;
          end else cntD = cntQ + 1'b1;
        end
        ST_STOP: begin
          if (fullBit) begin
            cntD = '0;
            if (!rxS && allLow) begin
              strb.pushBrk = 1'b1;
              stateD = ST_BRKWAIT;
            end else begin
              strb.pushChar = 1'b1;
              stateD = ST_IDLE;
            end
          end else cntD = cntQ + 1'b1;
        end
        ST_BRKWAIT: if (rxS) stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      bitQ   <= bitD;
    end
  end
endmodule

// File: rtl/ufr_datapath.sv
module ufr_datapath
  import ufr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  input  rxStrobe_t  strb,
  input  logic [1:0] wordLen,
  input  logic       parityOn,
  input  logic       evenSel,
  input  logic       stickSel,
  output logic       rxS,
  output logic       allLow,
  output rxEntry_t   entry
);
  logic [1:0] syncQ;
  logic [MAX_BITS-1:0] shQ, aligned;
  logic parQ, dataPar, expectBit;
  logic [2:0] shAmt;

  // two-flop synchronizer, reset to idle-high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end
  assign rxS = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ  <= '0;
      parQ <= 1'b0;
    end else begin
      if (strb.clrShift) begin
        shQ  <= '0;
        parQ <= 1'b0;
      end
      if (strb.shiftIn)    shQ  <= {rxS, shQ[MAX_BITS-1:1]};
      if (strb.takeParity) parQ <= rxS;
    end
  end

  // bits enter at the top; shorter words are moved down to bit 0
  assign shAmt     = 3'(MAX_BITS - 5) - {1'b0, wordLen};
  assign aligned   = shQ >> shAmt;
  assign dataPar   = ^aligned;
  assign expectBit = stickSel ? ~evenSel : (evenSel ? dataPar : ~dataPar);
  assign allLow    = (aligned == '0) && !(parityOn && parQ);

  always_comb begin
    entry.brk  = strb.pushBrk;
    entry.perr = strb.pushChar & parityOn & (parQ != expectBit);
    entry.ferr = strb.pushChar & ~rxS;
    entry.data = strb.pushBrk ? '0 : aligned;
  end
endmodule

// File: rtl/ufr_queue.sv
module ufr_queue
  import ufr_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fifoEn,
  input  logic            push,
  input  rxEntry_t        wrEntry,
  input  logic            pop,
  output rxEntry_t        head,
  output logic            notEmpty,
  output logic            overrun,
  output logic [CNTW-1:0] fill
);
  rxEntry_t mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CNTW-1:0] cap;
  logic full, doPush, doPop;

  assign cap      = fifoEn ? CNTW'(DEPTH) : CNTW'(1);
  assign full     = (fill >= cap);
  assign notEmpty = (fill != '0);
  assign doPush   = push & ~full;
  assign doPop    = pop & notEmpty;
  assign overrun  = push & full;
  assign head     = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[i] <= '0;
      else if (doPush && wrPtr == AW'(i)) mem[i] <= wrEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      fill <= fill + CNTW'(doPush) - CNTW'(doPop);
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import ufr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick16,
  input  logic                rxd,
  input  logic [1:0]          wordLen,
  input  logic                parityOn,
  input  logic                evenSel,
  input  logic                stickSel,
  input  logic                fifoEn,
  input  logic                popReq,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxParityErr,
  output logic                rxFrameErr,
  output logic                rxBreak,
  output logic                overrunPulse
);
  localparam int CNTW = $clog2(DEPTH + 1);

  rxStrobe_t strb;
  rxState_e  stateQ;
  rxEntry_t  newEntry, headEntry;
  logic rxS, allLow, pushAny;
  logic [CNTW-1:0] fillCount;

  assign pushAny = strb.pushChar | strb.pushBrk;

  ufr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(baudTick16), .rxS(rxS), .allLow(allLow),
    .parityOn(parityOn), .wordLen(wordLen), .strb(strb), .stateQ(stateQ)
  );

  ufr_datapath u_dp (
    .clk(clk), .rstN(rstN), .rxd(rxd), .strb(strb), .wordLen(wordLen),
    .parityOn(parityOn), .evenSel(evenSel), .stickSel(stickSel),
    .rxS(rxS), .allLow(allLow), .entry(newEntry)
  );

  ufr_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .push(pushAny), .wrEntry(newEntry),
    .pop(popReq), .head(headEntry), .notEmpty(rxValid), .overrun(overrunPulse),
    .fill(fillCount)
  );

  assign rxData      = headEntry.data;
  assign rxParityErr = headEntry.perr;
  assign rxFrameErr  = headEntry.ferr;
  assign rxBreak     = headEntry.brk;
endmodule

// File: rtl/ufr_checker.sv
module ufr_checker
  import ufr_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                fifoEn,
  input logic                popReq,
  input logic                rxValid,
  input logic [MAX_BITS-1:0] rxData,
  input logic                rxParityErr,
  input logic                rxFrameErr,
  input logic                rxBreak,
  input logic                overrunPulse,
  input logic                pushAny,
  input logic [CNTW-1:0]     fill,
  input rxState_e            state
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNTW'(DEPTH)); // R10
  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> fill <= CNTW'(1)); // R11
  AST_OVR_WHEN_STORED: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> rxValid); // R10
  AST_BRK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxData == '0 && !rxFrameErr && !rxParityErr)); // R8
  AST_BRK_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BRKWAIT |=> (state == ST_BRKWAIT || state == ST_IDLE)); // R8
  AST_POP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rxValid && fill == CNTW'(1) && !pushAny) |=> !rxValid); // R12
endmodule

bind uart_frame_rx ufr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .popReq(popReq), .rxValid(rxValid),
  .rxData(rxData), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
  .rxBreak(rxBreak), .overrunPulse(overrunPulse), .pushAny(pushAny),
  .fill(fillCount), .state(stateQ)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityOn = 1'b0, evenSel = 1'b0, stickSel = 1'b0, fifoEn = 1'b1, popReq = 1'b0;
  logic rxValid, rxParityErr, rxFrameErr, rxBreak, overrunPulse;
  logic [7:0] rxData;
  int tdiv = 0, checks = 0, errors = 0, ovrCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 1) ? 0 : tdiv + 1;
    tick <= (tdiv == 1);
    if (rstN && overrunPulse) ovrCount = ovrCount + 1;
  end

  uart_frame_rx #(.DEPTH(DEPTH)) u_uart_frame_rx (
    .clk(clk), .rstN(rstN), .baudTick16(tick), .rxd(rxd), .wordLen(wordLen),
    .parityOn(parityOn), .evenSel(evenSel), .stickSel(stickSel), .fifoEn(fifoEn),
    .popReq(popReq), .rxValid(rxValid), .rxData(rxData), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .overrunPulse(overrunPulse)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  // pm: 0 none, 1 odd, 2 even, 3 fixed with evenSel 0, 4 fixed with evenSel 1
  task automatic setCfg(int wl, int pm);
    wordLen  = 2'(wl);
    parityOn = (pm != 0);
    evenSel  = (pm == 2 || pm == 4);
    stickSel = (pm >= 3);
  endtask

  function automatic logic [7:0] maskOf(int wl);
    return 8'((1 << (5 + wl)) - 1);
  endfunction

  function automatic logic parBit(logic [7:0] d, int pm);
    logic ones = ^d;
    case (pm)
      1: return ~ones;
      2: return ones;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendFrame(logic [7:0] d, int wl, int pm, bit flipPar, bit stopLow, int nStop);
    logic [7:0] m = d & maskOf(wl);
    rxd = 1'b0; waitTicks(16);
    for (int i = 0; i < 5 + wl; i++) begin rxd = m[i]; waitTicks(16); end
    if (pm != 0) begin rxd = parBit(m, pm) ^ flipPar; waitTicks(16); end
    if (stopLow) begin
      rxd = 1'b0; waitTicks(12); rxd = 1'b1; waitTicks(20);
    end else begin
      rxd = 1'b1; waitTicks(16 * nStop);
    end
  endtask

  task automatic expectEntry(string req, logic [7:0] d, bit pe, bit fe, bit br);
    waitTicks(2);
    chk(req, "valid", rxValid, 1);
    chk(req, "data", rxData, d);
    chk(req, "parityErr", rxParityErr, pe);
    chk(req, "frameErr", rxFrameErr, fe);
    chk(req, "break", rxBreak, br);
    popReq = 1'b1; @(negedge clk); popReq = 1'b0; @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] vals [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    int ov0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", rxValid, 0);
    chk("R1", "overrun after reset", overrunPulse, 0);

    // R2: short glitch rejected
    rxd = 1'b0; waitTicks(4); rxd = 1'b1; waitTicks(40);
    chk("R2", "glitch valid", rxValid, 0);

    // R3 R4 R5 R6 R9: sweep word length, parity mode and data
    for (int wl = 0; wl < 4; wl++) begin
      for (int pm = 0; pm < 5; pm++) begin
        string preq = (pm == 0) ? "R6" : (pm >= 3) ? "R5" : "R4";
        setCfg(wl, pm);
        for (int k = 0; k < 5; k++) begin
          sendFrame(vals[k], wl, pm, 1'b0, 1'b0, 1 + (k % 2));
          waitTicks(2);
          chk(preq, "parity ok", rxParityErr, 0);
          expectEntry("R3", vals[k] & maskOf(wl), 1'b0, 1'b0, 1'b0);
          chk("R12", "empty after pop", rxValid, 0);
        end
        if (pm != 0) begin
          sendFrame(8'h5A, wl, pm, 1'b1, 1'b0, 1);
          expectEntry(preq, 8'h5A & maskOf(wl), 1'b1, 1'b0, 1'b0);
        end
      end
    end

    // R9: back-to-back frames with a single stop bit
    setCfg(3, 2);
    sendFrame(8'hC3, 3, 2, 1'b0, 1'b0, 1);
    sendFrame(8'h7E, 3, 2, 1'b0, 1'b0, 1);
    expectEntry("R9", 8'hC3, 1'b0, 1'b0, 1'b0);
    expectEntry("R9", 8'h7E, 1'b0, 1'b0, 1'b0);

    // R7: low stop bit on non-zero data
    setCfg(3, 0);
    sendFrame(8'h55, 3, 0, 1'b0, 1'b1, 1);
    waitTicks(16);
    expectEntry("R7", 8'h55, 1'b0, 1'b1, 1'b0);
    chk("R7", "no extra entry", rxValid, 0);

    // R8: break with even parity, line held low long
    setCfg(3, 2);
    rxd = 1'b0; waitTicks(16 * 11 + 80); rxd = 1'b1; waitTicks(30);
    expectEntry("R8", 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R8", "single break entry", rxValid, 0);

    // R10: queue fills, fifth character overruns
    setCfg(3, 0); fifoEn = 1'b1;
    ov0 = ovrCount;
    for (int i = 1; i <= DEPTH + 1; i++) sendFrame(8'(i * 17), 3, 0, 1'b0, 1'b0, 1);
    chk("R10", "overrun count", ovrCount - ov0, 1);
    for (int i = 1; i <= DEPTH; i++) expectEntry("R10", 8'(i * 17), 1'b0, 1'b0, 1'b0);
    chk("R10", "drained", rxValid, 0);

    // R11: single hold register
    fifoEn = 1'b0;
    ov0 = ovrCount;
    sendFrame(8'h11, 3, 0, 1'b0, 1'b0, 1);
    sendFrame(8'h22, 3, 0, 1'b0, 1'b0, 1);
    chk("R11", "overrun count", ovrCount - ov0, 1);
    expectEntry("R11", 8'h11, 1'b0, 1'b0, 1'b0);
    chk("R11", "hold empty", rxValid, 0);

    finishRun();
  end
endmodule